// File: doc/BRIEF.md
# Command-Driven Random Number Register Controller

This block is a memory-mapped random number peripheral. It has a 32-bit register interface, and software uses it by writing operation codes to a command register. A generate command makes the block take a stream of raw entropy bits into a 256-bit linear-feedback mixing register. After 128 or 256 accepted bits it copies the mixing state into eight readable output words and sets a ready flag. A reseed command makes the block take a fixed number of bits into the same register without publishing any output, and then sets a seed-done flag.

Both flags are cleared by writing a one to them. Software can route either flag to a single interrupt line, which is gated by a global enable. The block counts its output in 16-byte units. Once a programmed limit is reached, it starts a reseed on its own. The entropy source is outside the block and delivers one bit per cycle together with a valid strobe.

Top module: `trng_cmd_ctrl`

## Requirements
- R1: After reset:
  - the status register (0x14) reads 0x1, because the ready flag is set at power-up;
  - the output words, command, mode, interrupt enable and reseed-limit registers read zero;
  - offset 0xF0 reads 0x46BC;
  - irq is low.
- R2: Register readback:
  - Mode (0x08) keeps only bit 3.
  - Interrupt enable (0x10) keeps bits 31, 1 and 0.
  - Reseed limit (0x60) keeps bits 15:0.
  - Command (0x00) reads the active operation: 0 idle, 1 generating, 2 reseeding.
  - 0xF0 ignores writes.
  - Unmapped offsets read zero.
- R3: Entropy is absorbed only while an operation is active, and only on cycles with `ent_valid` high. Each absorbed bit shifts the 256-bit mixer state s left by one. The new bit 0 is s[255]^s[253]^s[250]^s[245]^ent_bit. The mixer state is zero after reset.
- R4: Writing 1 to the command register while idle starts generation. The length is 256 bits if mode bit 3 was 1 when the command was accepted, and 128 bits if it was 0. On the edge that absorbs the last bit:
  - output word k (at 0x20+4k) takes mixer bits [32k+31:32k], with the last bit included;
  - status bit 0 is set;
  - the block returns to idle.
- R5: A 128-bit generation updates words 0 to 3 and sets words 4 to 7 to zero.
- R6: Writing 2 while idle starts a reseed that absorbs 64 bits. When it finishes, status bit 1 is set, the output words are unchanged and the block returns to idle.
- R7: Command writes are ignored while an operation is active. While idle, the codes 0 and 3 or above leave the block idle.
- R8: Writing a one to a status bit clears it. Writing a zero leaves it unchanged.
- R9: irq = enable[31] & ((status[0] & enable[0]) | (status[1] & enable[1])).
- R10: Each generation adds 2 (for 256 bits) or 1 (for 128 bits) to a progress count. If the reseed limit is nonzero and the count reaches it, the block goes straight from generation into a 64-bit reseed and the count clears. A limit of zero disables this. Writing the reseed-limit register clears the progress count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ent_bit | input | 1 | Raw entropy bit |
| ent_valid | input | 1 | Entropy bit is valid this cycle |
| irq | output | 1 | Interrupt request |

## Verification
Any corruption of the mixer state or of its bit counter persists until the next publication, where it shows as wrong output words. The bench's arithmetic model of the shift rule shows this at the first generation after the fault. A wrong operation state shows within one cycle in the command readback at offset 0x00. A wrong progress count shows only at the generation where the automatic reseed should start, or where it starts but should not. The bench therefore steps the limit across values that are just reached, just missed, and cleared by a fresh write.

// File: rtl/trng_pkg.sv
package trng_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_GEN  = 2'd1,
    OP_SEED = 2'd2
  } op_e;

  localparam logic [7:0]  A_CMD    = 8'h00;
  localparam logic [7:0]  A_MODE   = 8'h08;
  localparam logic [7:0]  A_IEN    = 8'h10;
  localparam logic [7:0]  A_STS    = 8'h14;
  localparam logic [7:0]  A_WORD0  = 8'h20;
  localparam logic [7:0]  A_RESEED = 8'h60;
  localparam logic [7:0]  A_VER    = 8'hF0;
  localparam logic [31:0] VERSION_ID = 32'h0000_46BC;
  localparam int          MODE_LONG_BIT = 3;
endpackage

// File: rtl/trng_mixer.sv
module trng_mixer #(
  parameter int MIX_W = 256,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             absorb,
  input  logic [LEN_W-1:0] target,
  input  logic             ent_bit,
  input  logic             ent_valid,
  output logic [MIX_W-1:0] mix_next,
  output logic             last
);
  logic [MIX_W-1:0] state_q;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             take, fb;

  // feedback taps for x^256 + x^254 + x^251 + x^246 + 1
  assign fb   = state_q[MIX_W-1] ^ state_q[MIX_W-3] ^ state_q[MIX_W-6] ^
                state_q[MIX_W-11] ^ ent_bit;
  assign take = absorb & ent_valid;
  assign last = take & (cnt_q == target - LEN_W'(1));

  always_comb begin
    mix_next = take ? {state_q[MIX_W-2:0], fb} : state_q;
    if (!absorb)   cnt_d = '0;
    else if (last) cnt_d = '0;
    else if (take) cnt_d = cnt_q + LEN_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '0;
    else if (take) state_q <= mix_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    absorb |-> (cnt_q < target)); // R3
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !absorb |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/trng_seq.sv
module trng_seq
  import trng_pkg::*;
#(
  parameter int MIX_W     = 256,
  parameter int LEN_W     = 9,
  parameter int SEED_BITS = 64,
  parameter int LIM_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  input  logic             mode_long,
  input  logic [LIM_W-1:0] lim,
  input  logic             lim_wr,
  input  logic             last,
  output op_e              op,
  output logic [LEN_W-1:0] target,
  output logic             long_q,
  output logic             gen_done,
  output logic             seed_done
);
  op_e              op_q, op_d;
  logic             long_d;
  logic [LIM_W-1:0] units_q, units_d;
  logic [LIM_W:0]   units_sum;
  logic             due;

  assign op        = op_q;
  assign gen_done  = (op_q == OP_GEN)  & last;
  assign seed_done = (op_q == OP_SEED) & last;
  assign units_sum = {1'b0, units_q} + (long_q ? (LIM_W+1)'(2) : (LIM_W+1)'(1));
  assign due       = (lim != '0) & (units_sum >= {1'b0, lim});

  always_comb begin
    if (op_q == OP_SEED) target = LEN_W'(SEED_BITS);
    else if (long_q)     target = LEN_W'(MIX_W);
    else                 target = LEN_W'(MIX_W / 2);
  end

  always_comb begin
    op_d   = op_q;
    long_d = long_q;
    unique case (op_q)
      OP_IDLE: if (cmd_wr) begin
        if (cmd_wdata == 32'd1) begin
          op_d   = OP_GEN;
          long_d = mode_long;
        end else if (cmd_wdata == 32'd2) begin
          op_d = OP_SEED;
        end
      end
      OP_GEN:  if (last) op_d = due ? OP_SEED : OP_IDLE;
      OP_SEED: if (last) op_d = OP_IDLE;
      default: op_d = OP_IDLE;
    endcase
  end

  always_comb begin
    units_d = units_q;
    if (lim_wr)        units_d = '0;
    else if (gen_done) units_d = due ? '0 : units_sum[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      long_q  <= 1'b0;
      units_q <= '0;
    end else begin
      op_q    <= op_d;
      long_q  <= long_d;
      units_q <= units_d;
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_q != OP_IDLE) && !last) |=> (op_q == $past(op_q))); // R7
  AST_SEED_END: assert property (@(posedge clk) disable iff (!rst_n)
    seed_done |=> (op_q == OP_IDLE)); // R6
  AST_AUTO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_done && due) |=> (op_q == OP_SEED)); // R10
endmodule

// File: rtl/trng_cmd_ctrl.sv
module trng_cmd_ctrl
  import trng_pkg::*;
#(
  parameter int NWORDS    = 8,
  parameter int SEED_BITS = 64,
  parameter int LIM_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ent_bit,
  input  logic        ent_valid,
  output logic        irq
);
  localparam int WORD_W = 32;
  localparam int MIX_W  = NWORDS * WORD_W;
  localparam int LEN_W  = $clog2(MIX_W) + 1;
  localparam int IDX_W  = $clog2(NWORDS);

  op_e              op;
  logic [LEN_W-1:0] target;
  logic             long_q, gen_done, seed_done, last;
  logic [MIX_W-1:0] mix_next;
  logic             mode_q;
  logic [2:0]       ien_q;
  logic [1:0]       sts_q, sts_d;
  logic [LIM_W-1:0] lim_q;
  logic [WORD_W-1:0] words_q [NWORDS];
  logic             wr_cmd, wr_mode, wr_ien, wr_sts, wr_lim;
  logic [7:0]       woff;
  logic             in_words;
  logic [IDX_W-1:0] widx;

  assign wr_cmd  = reg_we & (reg_addr == A_CMD);
  assign wr_mode = reg_we & (reg_addr == A_MODE);
  assign wr_ien  = reg_we & (reg_addr == A_IEN);
  assign wr_sts  = reg_we & (reg_addr == A_STS);
  assign wr_lim  = reg_we & (reg_addr == A_RESEED);

  trng_seq #(.MIX_W(MIX_W), .LEN_W(LEN_W), .SEED_BITS(SEED_BITS), .LIM_W(LIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd), .cmd_wdata(reg_wdata),
    .mode_long(mode_q), .lim(lim_q), .lim_wr(wr_lim), .last(last),
    .op(op), .target(target), .long_q(long_q),
    .gen_done(gen_done), .seed_done(seed_done)
  );

  trng_mixer #(.MIX_W(MIX_W), .LEN_W(LEN_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .absorb(op != OP_IDLE), .target(target),
    .ent_bit(ent_bit), .ent_valid(ent_valid), .mix_next(mix_next), .last(last)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ien_q  <= '0;
      lim_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[MODE_LONG_BIT];
      if (wr_ien)  ien_q  <= {reg_wdata[31], reg_wdata[1], reg_wdata[0]};
      if (wr_lim)  lim_q  <= reg_wdata[LIM_W-1:0];
    end
  end

  // status: event sets, write-one clears, set wins
  always_comb begin
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_q & ~reg_wdata[1:0];
    if (gen_done)  sts_d[0] = 1'b1;
    if (seed_done) sts_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 2'b01;
    else        sts_q <= sts_d;
  end

  // output words
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words_q[k] <= '0;
      else if (gen_done) begin
        if (k < NWORDS / 2 || long_q) words_q[k] <= mix_next[k*WORD_W +: WORD_W];
        else                          words_q[k] <= '0;
      end
    end
  end

  assign irq = ien_q[2] & ((sts_q[0] & ien_q[0]) | (sts_q[1] & ien_q[1]));

  // read mux
  assign woff     = reg_addr - A_WORD0;
  assign in_words = (reg_addr >= A_WORD0) && (woff < 8'(4 * NWORDS)) && (reg_addr[1:0] == 2'b00);
  assign widx     = woff[IDX_W+1:2];

  always_comb begin
    reg_rdata = '0;
    if (in_words) reg_rdata = words_q[widx];
    else begin
      unique case (reg_addr)
        A_CMD:    reg_rdata = {30'b0, op};
        A_MODE:   reg_rdata = {28'b0, mode_q, 3'b0};
        A_IEN:    reg_rdata = {ien_q[2], 29'b0, ien_q[1:0]};
        A_STS:    reg_rdata = {30'b0, sts_q};
        A_RESEED: reg_rdata = {{(32-LIM_W){1'b0}}, lim_q};
        A_VER:    reg_rdata = VERSION_ID;
        default:  reg_rdata = '0;
      endcase
    end
  end

  AST_RDY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> ($past(op) == OP_GEN)); // R4
  AST_SEED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[1]) |-> ($past(op) == OP_SEED)); // R6
  AST_HALF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_done) && !$past(long_q)) |-> (words_q[NWORDS-1] == '0)); // R5
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gen_done) |-> $stable(words_q[0])); // R6
endmodule

// File: tb/tb_trng_cmd_ctrl.sv
module tb_trng_cmd_ctrl;
  localparam int PERIOD = 10;

  logic        clk, rst_n, reg_we, ent_bit, ent_valid, irq;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  trng_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_bit(ent_bit),
    .ent_valid(ent_valid), .irq(irq)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int nvec = 0, nbad = 0;
  bit finished = 0;

  // bench model
  logic [255:0] m;
  int           cnt, op, units, lim;
  bit           long_l, mode, s0, s1;
  logic [2:0]   ie;
  logic [31:0]  ew [8];
  logic [31:0]  lcg;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 8; k++) rd_chk(tag, 8'(32 + 4*k), ew[k]);
    rd_chk(tag, 8'h14, {30'b0, s1, s0});
    rd_chk(tag, 8'h00, 32'(op));
    check({tag, " irq"}, {31'b0, irq}, {31'b0, ie[2] & ((s0 & ie[0]) | (s1 & ie[1]))});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    case (a)
      8'h00: if (op == 0) begin
        if (d == 1) begin op = 1; long_l = mode; end
        else if (d == 2) op = 2;
      end
      8'h08: mode = d[3];
      8'h10: ie = {d[31], d[1], d[0]};
      8'h14: begin if (d[0]) s0 = 0; if (d[1]) s1 = 0; end
      8'h60: begin lim = int'(d[15:0]); units = 0; end
      default: ;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic feed();
    logic b;
    int tgt;
    lcg = lcg * 32'd1103515245 + 32'd12345;
    b = lcg[16];
    if (lcg[20:18] == 3'b000) begin   // occasional gap cycle
      ent_valid = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    ent_valid = 1'b1; ent_bit = b;
    @(posedge clk);
    if (op != 0) begin
      m = {m[254:0], m[255] ^ m[253] ^ m[250] ^ m[245] ^ b};
      cnt++;
      tgt = (op == 2) ? 64 : (long_l ? 256 : 128);
      if (cnt == tgt) begin
        cnt = 0;
        if (op == 1) begin
          for (int k = 0; k < 8; k++) ew[k] = (k < 4 || long_l) ? m[32*k +: 32] : 32'h0;
          s0 = 1;
          units += long_l ? 2 : 1;
          if (lim != 0 && units >= lim) begin units = 0; op = 2; end
          else op = 0;
        end else begin
          s1 = 1; op = 0;
        end
      end
    end
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic run_gen(input bit lng);
    wr(8'h08, lng ? 32'h8 : 32'h0);
    wr(8'h00, 32'd1);
    while (op == 1) feed();
  endtask

  initial begin
    m = '0; cnt = 0; op = 0; units = 0; lim = 0; long_l = 0; mode = 0;
    s0 = 1; s1 = 0; ie = '0; lcg = 32'h1234_5678;
    for (int k = 0; k < 8; k++) ew[k] = '0;
    rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0; ent_bit = 0; ent_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 reset");
    rd_chk("R1 version", 8'hF0, 32'h46BC);
    rd_chk("R1 mode", 8'h08, 32'h0);
    rd_chk("R1 ien", 8'h10, 32'h0);
    rd_chk("R1 limit", 8'h60, 32'h0);

    // R2 register readback
    wr(8'hF0, 32'hFFFF_FFFF);
    rd_chk("R2 version ro", 8'hF0, 32'h46BC);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R2 mode bits", 8'h08, 32'h8);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R2 ien bits", 8'h10, 32'h8000_0003);
    wr(8'h10, 32'h0);
    wr(8'h60, 32'hABCD_0000);
    rd_chk("R2 limit bits", 8'h60, 32'h0);
    rd_chk("R2 unmapped", 8'h04, 32'h0);
    rd_chk("R2 unmapped", 8'h44, 32'h0);

    // R8 write-one clear
    wr(8'h14, 32'h0);
    rd_chk("R8 write zero keeps", 8'h14, 32'h1);
    wr(8'h14, 32'h1);
    rd_chk("R8 w1c", 8'h14, 32'h0);

    // R3 idle bits are not absorbed
    for (int i = 0; i < 12; i++) feed();
    rd_chk("R3 idle", 8'h00, 32'h0);

    // R4 R5 sweep across modes
    for (int rep = 0; rep < 8; rep++) begin
      wr(8'h08, (rep % 2) ? 32'h8 : 32'h0);
      wr(8'h00, 32'd1);
      rd_chk("R4 busy reads 1", 8'h00, 32'h1);
      if (rep == 3) begin
        wr(8'h08, 32'h0);       // R4 length latched at start
        wr(8'h00, 32'd2);       // R7 ignored while busy
        wr(8'h00, 32'd0);
        rd_chk("R7 busy ignore", 8'h00, 32'h1);
      end
      while (op == 1) feed();
      check_all((rep % 2) ? "R4 gen256" : "R5 gen128");
      wr(8'h14, 32'h1);
      check_all("R8 clear ready");
    end

    // R6 reseed
    wr(8'h00, 32'd2);
    rd_chk("R6 seeding reads 2", 8'h00, 32'h2);
    while (op == 2) feed();
    check_all("R6 seed done");
    run_gen(1'b1);
    check_all("R6 gen after seed");
    wr(8'h14, 32'h3);

    // R7 nop and unknown codes
    wr(8'h00, 32'd0);
    rd_chk("R7 nop", 8'h00, 32'h0);
    wr(8'h00, 32'd3);
    rd_chk("R7 code3", 8'h00, 32'h0);
    wr(8'h00, 32'h101);
    rd_chk("R7 wide code", 8'h00, 32'h0);

    // R9 interrupt
    wr(8'h10, 32'h1);
    run_gen(1'b0);
    check_all("R9 no global");
    wr(8'h10, 32'h8000_0001);
    check_all("R9 ready irq");
    wr(8'h14, 32'h1);
    check_all("R9 cleared");
    wr(8'h10, 32'h8000_0002);
    wr(8'h00, 32'd2);
    while (op == 2) feed();
    check_all("R9 seed irq");
    wr(8'h14, 32'h2);
    check_all("R9 seed cleared");
    wr(8'h10, 32'h0);

    // R10 automatic reseed
    wr(8'h60, 32'd3);
    run_gen(1'b1);
    check_all("R10 below limit");
    run_gen(1'b0);
    check_all("R10 auto start");
    while (op == 2) feed();
    check_all("R10 auto done");
    wr(8'h14, 32'h3);
    run_gen(1'b1);
    wr(8'h60, 32'd3);         // R10 rewrite clears progress
    run_gen(1'b1);
    check_all("R10 rewrite clears");
    wr(8'h60, 32'd0);
    for (int i = 0; i < 4; i++) begin
      run_gen(1'b1);
      check_all("R10 disabled");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule